// File: doc/BRIEF.md
# Two-Wire Slave Transmitter with Status Codes

This block is a two-wire (I2C) bus slave that returns data to an external bus master. A processor controls it through a small register port: a control register, a read-only status register that reports the protocol state as one byte, a transmit-data register and an own-address register. Each time the block reaches a protocol step that needs software attention, it raises an interrupt flag. While that flag is set during a read transfer, the block holds SCL low, so software has time to supply the next byte.

Both bus lines are open-drain. The block only ever pulls a line low, and it releases both lines whenever it has nothing to drive. A START or STOP that appears in the middle of an address byte, a data byte or an acknowledge bit is reported as a bus error, and software must clear that error explicitly. The same block also produces a bit-rate half-period tick. The tick comes from one of seven fixed system-clock divisors, or it follows an external timer pulse.

Top module: `i2c_slave_tx_ctrl`

## Requirements
- R1: The status register (address 1) reads F8h whenever the interrupt flag (control bit 3) is 0, including after reset. After reset, every register reads 0 except status, and neither line is driven.
- R2: When enabled (control bit 6) with acknowledge-enable set (control bit 7), an address byte whose upper seven bits equal own-address register bits [6:0] and whose last bit is 1 is acknowledged by pulling SDA low for the ninth clock. After that clock the interrupt flag sets, status becomes A8h, and SCL is held low until software clears the flag.
- R3: An address byte with a different address, with a last bit of 0, or received while acknowledge-enable is 0 gets no acknowledge and does not set the interrupt flag. Recognition works again as soon as acknowledge-enable is set.
- R4: Clearing the interrupt flag while transmitting loads the data register (address 2), which is then sent MSB first. If the master acknowledges and acknowledge-enable is still 1, status becomes B8h and SCL is held again.
- R5: If the master does not acknowledge a byte, status becomes C0h, the block becomes unaddressed, and SDA is released.
- R6: If acknowledge-enable is cleared while a byte is being shifted out, that byte is completed. An acknowledge from the master then gives status C8h, and any further bytes the master reads are all ones and set no flag.
- R7: A START or STOP seen during an address byte (after its first bit), during a data byte or during an acknowledge bit gives status 00h and sets the interrupt flag. Both lines are released.
- R8: Writing the stop flag (control bit 4) as 1 together with the interrupt flag as 0 leaves the block unaddressed. The stop flag then clears itself, the other control bits keep their values, and no line is driven.
- R9: Software can clear the interrupt flag by writing 0 to it. Writing 1 to it does not set it.
- R10: Rate code (control bits [2:0]) values 0,1,2,3,5,6,7 give a rate tick every 128, 112, 96, 80, 480, 60, 30 clocks. Code 4 passes the external timer tick straight through.
- R11: While control bit 6 is 0, neither line is ever driven, no flag is set and the rate tick stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt flag |
| tmr_tick | input | 1 | External timer pulse used by rate code 4 |
| rate_tick | output | 1 | Bit-rate half-period tick |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume the following about the inputs:
- The master changes SDA only while SCL is low, except when it means to create a START or STOP.
- Each line level stays stable for several system clocks, so the two-flop synchronizers see every edge.
- The interrupt flag falls only because of a register write.

The bench keeps within these assumptions. Its master holds every bus phase for twenty clocks. It waits for SCL to rise after releasing it, which allows for stretching. It creates the injected STOP by raising SDA during an SCL high phase in which the slave is sending a 1.

// File: rtl/i2c_slave_tx_ctrl.sv
module i2c_slave_tx_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       tmr_tick,
  output logic       rate_tick,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam logic [7:0] ST_NONE = 8'hF8;
  localparam logic [7:0] ST_BERR = 8'h00;
  localparam logic [7:0] ST_SLAR = 8'hA8;
  localparam logic [7:0] ST_DACK = 8'hB8;
  localparam logic [7:0] ST_DNAK = 8'hC0;
  localparam logic [7:0] ST_LAST = 8'hC8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_TX, S_TACK, S_ERR} st_t;

  st_t        st;
  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  logic [2:0] rate;
  logic       si, sto, en, aa;
  logic [6:0] own;
  logic [7:0] dreg, sh, code;
  logic [3:0] bcnt;
  logic       ackd;
  logic [8:0] cnt, half;

  logic scl_now, sda_now, scl_rise, scl_fall, start_c, stop_c;
  logic ctl_wr, si_clr, cnt_hit, bus_err;

  assign scl_now  = scl_s[1];
  assign sda_now  = sda_s[1];
  assign scl_rise = scl_now & ~scl_q;
  assign scl_fall = ~scl_now & scl_q;
  assign start_c  = scl_now & scl_q & sda_q & ~sda_now;
  assign stop_c   = scl_now & scl_q & ~sda_q & sda_now;

  assign ctl_wr = reg_we && reg_addr == 2'd0;
  assign si_clr = ctl_wr && !reg_wdata[3] && si;

  always_comb begin
    case (rate)
      3'd0:    half = 9'd128;
      3'd1:    half = 9'd112;
      3'd2:    half = 9'd96;
      3'd3:    half = 9'd80;
      3'd5:    half = 9'd480;
      3'd6:    half = 9'd60;
      3'd7:    half = 9'd30;
      default: half = 9'd0;
    endcase
  end

  assign cnt_hit   = (cnt == half - 9'd1);
  assign rate_tick = en & ((rate == 3'd4) ? tmr_tick : cnt_hit);

  always_comb begin
    bus_err = 1'b0;
    if (en && (start_c || stop_c)) begin
      case (st)
        S_ADDR:                bus_err = stop_c || bcnt != 4'd0;
        S_AACK, S_TX, S_TACK:  bus_err = 1'b1;
        default:               bus_err = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      rate  <= '0;
      si    <= 1'b0;
      sto   <= 1'b0;
      en    <= 1'b0;
      aa    <= 1'b0;
      own   <= '0;
      dreg  <= '0;
      sh    <= '0;
      code  <= ST_NONE;
      bcnt  <= '0;
      ackd  <= 1'b0;
      cnt   <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_now;
      sda_q <= sda_now;
      cnt   <= (ctl_wr || cnt_hit) ? 9'd0 : cnt + 9'd1;

      if (reg_we) begin
        case (reg_addr)
          2'd0: begin
            rate <= reg_wdata[2:0];
            sto  <= reg_wdata[4];
            en   <= reg_wdata[6];
            aa   <= reg_wdata[7];
            if (!reg_wdata[3]) si <= 1'b0;
          end
          2'd2:    dreg <= reg_wdata;
          2'd3:    own  <= reg_wdata[6:0];
          default: ;
        endcase
      end

      if (!en) begin
        st <= S_IDLE;
      end else if (sto && !si) begin
        st  <= S_IDLE;
        sto <= 1'b0;
      end else if (bus_err) begin
        st   <= S_ERR;
        si   <= 1'b1;
        code <= ST_BERR;
      end else begin
        case (st)
          S_IDLE: if (start_c) begin
            st   <= S_ADDR;
            bcnt <= '0;
          end
          S_ADDR: begin
            if (start_c) bcnt <= '0;
            else if (scl_rise) begin
              sh   <= {sh[6:0], sda_now};
              bcnt <= bcnt + 4'd1;
            end else if (scl_fall && bcnt == 4'd8)
              st <= (sh[7:1] == own && sh[0] && aa) ? S_AACK : S_IDLE;
          end
          S_AACK: if (scl_fall) begin
            st   <= S_TX;
            si   <= 1'b1;
            code <= ST_SLAR;
            bcnt <= '0;
          end
          S_TX: begin
            if (si_clr) sh <= dreg;
            else if (scl_fall) begin
              sh <= {sh[6:0], 1'b1};
              if (bcnt == 4'd7) st <= S_TACK;
              else bcnt <= bcnt + 4'd1;
            end
          end
          S_TACK: begin
            if (scl_rise) ackd <= ~sda_now;
            else if (scl_fall) begin
              si   <= 1'b1;
              code <= !ackd ? ST_DNAK : (aa ? ST_DACK : ST_LAST);
              st   <= (ackd && aa) ? S_TX : S_IDLE;
              bcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign irq    = si;
  assign sda_oe = (st == S_AACK) | (st == S_TX & ~si & ~sh[7]);
  assign scl_oe = (st == S_TX) & si;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {aa, en, 1'b0, sto, si, rate};
      2'd1:    reg_rdata = si ? code : ST_NONE;
      2'd2:    reg_rdata = dreg;
      default: reg_rdata = {1'b0, own};
    endcase
  end

  a_r9_si_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(si) |-> $past(reg_we && reg_addr == 2'd0 && !reg_wdata[3]));
  a_r8_sto_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sto) |-> ($past(!si) || $past(reg_we && reg_addr == 2'd0)));
  a_r7_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    (si && code == ST_BERR) |-> (!sda_oe && !scl_oe));
  a_r5_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (si && code == ST_DNAK) |-> !sda_oe);
  a_r2_stretch_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> (code == ST_SLAR || code == ST_DACK));
  a_r11_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!sda_oe && !scl_oe && !rate_tick));
endmodule

// File: tb/i2c_slave_tx_ctrl_bench.sv
module i2c_slave_tx_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, rate_tick, scl_oe, sda_oe;
  logic       tmr_tick = 1'b0;
  logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic       scl_line, sda_line;
  logic       drv_seen = 1'b0;
  int n_tests = 0, n_fail = 0;

  assign scl_line = ~(m_scl_low | scl_oe);
  assign sda_line = ~(m_sda_low | sda_oe);

  i2c_slave_tx_ctrl u_i2c_slave_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .tmr_tick(tmr_tick), .rate_tick(rate_tick), .scl_i(scl_line),
    .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always @(negedge clk) if (sda_oe || scl_oe) drv_seen = 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0; wait_clk(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
    m_sda_low = 1'b1; wait_clk(Q);
    m_scl_low = 1'b1; wait_clk(Q);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1; wait_clk(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
    m_sda_low = 1'b0; wait_clk(Q);
  endtask

  task automatic m_wbit(input logic b);
    m_sda_low = !b; wait_clk(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clk(2*Q);
    m_scl_low = 1'b1; wait_clk(Q);
  endtask

  task automatic m_rbit(output logic b);
    m_sda_low = 1'b0; wait_clk(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
    b = sda_line; wait_clk(Q);
    m_scl_low = 1'b1; wait_clk(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_wbit(d[i]);
    m_rbit(b);
    ack = !b;
  endtask

  task automatic m_rbyte(input logic send_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) m_rbit(d[i]);
    m_wbit(!send_ack);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 control after reset", d, 8'h00);
    rd(2'd1, d); chk("R1 status after reset", d, 8'hF8);
    rd(2'd2, d); chk("R1 data after reset", d, 8'h00);
    chk("R1 lines after reset", {sda_oe, scl_oe, irq}, 0);
  endtask

  task automatic t_si_write_one();
    logic [7:0] d;
    wr(2'd0, 8'hC8);
    rd(2'd0, d); chk("R9 si not set by write", d, 8'hC0);
    chk("R9 irq stays low", irq, 0);
  endtask

  task automatic meas(input logic [2:0] code, input int exp_n);
    int n;
    wr(2'd0, {5'b01000, code});
    while (!rate_tick) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (!rate_tick);
    chk($sformatf("R10 rate code %0d interval", code), n, exp_n);
  endtask

  task automatic t_rate();
    meas(3'd0, 128);
    meas(3'd3, 80);
    meas(3'd5, 480);
    meas(3'd7, 30);
    wr(2'd0, 8'h44);
    @(negedge clk); tmr_tick = 1'b1; #1;
    chk("R10 code 4 follows timer high", rate_tick, 1);
    @(negedge clk); tmr_tick = 1'b0; #1;
    chk("R10 code 4 follows timer low", rate_tick, 0);
  endtask

  task automatic t_disabled();
    logic ack;
    logic [7:0] d;
    int ticks;
    wr(2'd3, 8'h2A);
    wr(2'd0, 8'h80);
    drv_seen = 1'b0;
    m_start(); m_wbyte({7'h2A, 1'b1}, ack); m_stop();
    chk("R11 no ack while disabled", ack, 0);
    chk("R11 no line driven while disabled", drv_seen, 0);
    rd(2'd1, d); chk("R11 no flag while disabled", d, 8'hF8);
    ticks = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (rate_tick) ticks++; end
    chk("R11 rate tick quiet", ticks, 0);
  endtask

  task automatic t_nomatch();
    logic ack;
    logic [7:0] d;
    wr(2'd0, 8'hC0);
    m_start(); m_wbyte({7'h2B, 1'b1}, ack); m_stop();
    chk("R3 other address no ack", ack, 0);
    m_start(); m_wbyte({7'h2A, 1'b0}, ack); m_stop();
    chk("R3 write direction no ack", ack, 0);
    wr(2'd0, 8'h40);
    m_start(); m_wbyte({7'h2A, 1'b1}, ack); m_stop();
    chk("R3 acknowledge-enable off no ack", ack, 0);
    rd(2'd1, d); chk("R3 status stays F8", d, 8'hF8);
  endtask

  task automatic addr_ok(input string req);
    logic ack;
    logic [7:0] d;
    m_start(); m_wbyte({7'h2A, 1'b1}, ack);
    chk({req, " address acked"}, ack, 1);
    rd(2'd1, d); chk({req, " status A8"}, d, 8'hA8);
  endtask

  task automatic t_read();
    logic [7:0] d;
    wr(2'd0, 8'hC0);
    addr_ok("R2");
    chk("R2 irq and SCL held", {irq, scl_oe}, 2'b11);
    wr(2'd2, 8'h96); wr(2'd0, 8'hC0);
    m_rbyte(1'b1, d);
    chk("R4 first byte", d, 8'h96);
    rd(2'd1, d); chk("R4 status B8", d, 8'hB8);
    chk("R4 SCL held after byte", scl_oe, 1);
    wr(2'd2, 8'h3C); wr(2'd0, 8'hC0);
    m_rbyte(1'b0, d);
    chk("R4 second byte", d, 8'h3C);
    rd(2'd1, d); chk("R5 status C0", d, 8'hC0);
    chk("R5 lines released", {sda_oe, scl_oe}, 0);
    wr(2'd0, 8'hC0);
    m_stop();
    rd(2'd1, d); chk("R1 status F8 after cleared", d, 8'hF8);
  endtask

  task automatic t_aa_drop();
    logic [7:0] d;
    wr(2'd0, 8'hC0);
    addr_ok("R6");
    wr(2'd2, 8'h5A); wr(2'd0, 8'hC0);
    fork
      m_rbyte(1'b1, d);
      begin wait_clk(200); wr(2'd0, 8'h40); end
    join
    chk("R6 byte completed", d, 8'h5A);
    rd(2'd1, d); chk("R6 status C8", d, 8'hC8);
    wr(2'd0, 8'h40);
    m_rbyte(1'b1, d);
    chk("R6 further read all ones", d, 8'hFF);
    chk("R6 no flag on further read", irq, 0);
    m_stop();
    wr(2'd0, 8'hC0);
    addr_ok("R3 resume");
    wr(2'd2, 8'h11); wr(2'd0, 8'hC0);
    m_rbyte(1'b0, d);
    wr(2'd0, 8'hC0);
    m_stop();
  endtask

  task automatic t_buserr();
    logic [7:0] d;
    wr(2'd0, 8'hC0);
    addr_ok("R7");
    wr(2'd2, 8'hF0); wr(2'd0, 8'hC0);
    m_sda_low = 1'b1; wait_clk(Q);
    m_scl_low = 1'b0; wait_scl_high(); wait_clk(Q);
    m_sda_low = 1'b0; wait_clk(Q);
    rd(2'd1, d); chk("R7 status 00", d, 8'h00);
    chk("R7 irq set", irq, 1);
    chk("R7 lines released", {sda_oe, scl_oe}, 0);
    drv_seen = 1'b0;
    wr(2'd0, 8'hD0);
    wait_clk(4);
    rd(2'd0, d); chk("R8 stop flag cleared, others kept", d, 8'hC0);
    rd(2'd1, d); chk("R8 status F8 after recovery", d, 8'hF8);
    chk("R8 nothing driven in recovery", drv_seen, 0);
    addr_ok("R8");
    wr(2'd2, 8'h22); wr(2'd0, 8'hC0);
    m_rbyte(1'b0, d);
    chk("R8 byte after recovery", d, 8'h22);
    wr(2'd0, 8'hC0);
    m_stop();
  endtask

  initial begin
    wait_clk(150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_si_write_one();
    t_rate();
    t_disabled();
    t_nomatch();
    t_read();
    t_aa_drop();
    t_buserr();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule